// File: doc/BRIEF.md
# Instruction group prefix parser

This block sits in an instruction front end that delivers 16-bit parcels through a valid/ready handshake. It recognises the header parcel of a variable-length instruction group and decodes its length and section counts from that parcel. It then classifies every following parcel of the group as a vector-length parcel, a predicate tag parcel, a register tag parcel or an ordinary opcode parcel. Tag parcels are presented on a tag output as one wide entry or two narrow lanes. Opcode parcels are forwarded on a valid/ready opcode output. The last parcel of a group is flagged.

When a vector-length parcel is present, the block carries out its settings. It updates the current vector length, the maximum vector length and the sub-vector grouping. It may also request a write of the new length into a scalar register. In one mode the length source is a register, and the block reads it through a combinational read port. Malformed headers are reported and dropped, and the next parcel is taken as a fresh header.

Top module: `svg_prefix_parser`

## Requirements
- R1: A header parcel is accepted only when bits 6:0 are 1111111, the length field IL (bits 14:12) is not 111, and 1 + V + P + G does not exceed 5 + IL. Here V is bit 15, P is bits 11:10 and G is bits 9:8. Otherwise `hdr_err_o` is high for the cycle in which that parcel is offered, and the following parcel is again treated as a header.
- R2: An accepted group spans 5 + IL parcels, header included. `grp_end_o` is high exactly when the last of them is accepted, and the next parcel is treated as a header.
- R3: The parcels after the header are taken in a fixed order. First comes one vector-length parcel if V is 1. Then come P predicate tag parcels and G register tag parcels. Every remaining parcel is an opcode parcel and appears on `op_valid_o`/`op_data_o`. Tag outputs are all zero on non-tag cycles.
- R4: With header bit 7 set (wide format), a tag parcel is one entry and `tag_valid_o` = 01. With bit 7 clear (narrow format), a tag parcel holds two 8-bit entries: lane 0 is bits 7:0 and lane 1 is bits 15:8. Each lane is valid only when its byte is nonzero, since a byte of 0x00 is padding.
- R5: `tag_idx_o` is the index of the lane-0 entry within its section. It equals the parcel number in wide format and twice the parcel number in narrow format. For narrow predicate entries, `tag_preg_o` gives the implied predicate register for each lane, counted from 9: lane 0 is in bits 4:0 and lane 1 in bits 9:5. Otherwise `tag_preg_o` is 0.
- R6: A vector-length parcel has bit 15 as the mode, bits 14:13 as SUBVL-1, bits 12:8 as the destination register and bits 5:0 as the length field. In mode 0 with bit 0 clear, VL becomes MIN(bits 5:1 + 1, MAXVL) and MAXVL is unchanged.
- R7: In mode 0 with bit 0 set, `sreg_raddr_o` carries bits 5:1 in that cycle, and VL becomes `sreg_rdata_i` clamped to the range 1..MAXVL. `sreg_raddr_o` is 0 in all other cycles.
- R8: In mode 1, MAXVL and VL both become MIN(bits 5:0 + 1, VL_MAX).
- R9: Every vector-length parcel sets SUBVL to bits 14:13 plus 1.
- R10: When the destination field of a vector-length parcel is nonzero, `sreg_we_o` pulses in that cycle. It carries `sreg_waddr_o` equal to that field and `sreg_wdata_o` equal to the new VL. With a zero destination there is no write. The new VL, MAXVL and SUBVL appear on the outputs from the next cycle.
- R11: `in_ready_o` is low only while an opcode parcel is offered and `op_ready_i` is low. A stalled parcel stays in place and is forwarded once `op_ready_i` rises, with no parcel lost or repeated.
- R12: After reset the parser waits for a header, VL, MAXVL and SUBVL are 1, and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Parcel offered |
| in_ready_o | output | 1 | Parcel taken this cycle when valid |
| in_data_i | input | 16 | Incoming parcel |
| op_valid_o | output | 1 | Opcode parcel valid |
| op_ready_i | input | 1 | Opcode consumer ready |
| op_data_o | output | 16 | Opcode parcel |
| grp_end_o | output | 1 | Last parcel of group accepted |
| hdr_err_o | output | 1 | Malformed header offered |
| tag_valid_o | output | 2 | Tag lane valid flags |
| tag_is_pred_o | output | 1 | Tag belongs to predicate section |
| tag_full_o | output | 1 | Tag is one wide entry |
| tag_data_o | output | 16 | Tag parcel contents |
| tag_idx_o | output | 3 | Section index of lane-0 entry |
| tag_preg_o | output | 10 | Implied predicate registers for narrow lanes |
| sreg_raddr_o | output | 5 | Scalar register read address |
| sreg_rdata_i | input | XLEN | Scalar register read data |
| sreg_we_o | output | 1 | Scalar register write strobe |
| sreg_waddr_o | output | 5 | Scalar register write address |
| sreg_wdata_o | output | XLEN | Scalar register write data |
| vl_o | output | VLW | Current vector length |
| maxvl_o | output | VLW | Current maximum vector length |
| subvl_o | output | 3 | Current sub-vector length |

## Verification
A wrong parcel counter or a wrong latched section count misclassifies a parcel. That shows up in the same cycle as a tag strobe on an opcode parcel, an opcode on a tag parcel, or `grp_end_o` at the wrong place. It then corrupts every later group, because the header is looked for at the wrong parcel. A wrong length calculation shows on `sreg_wdata_o` in the cycle of the vector-length parcel, and on `vl_o`/`maxvl_o` one cycle later. A stall that advances the counter shows as a lost opcode on the next accepted parcel.

// File: rtl/svg_pkg.sv
`timescale 1ns/1ps
package svg_pkg;
  localparam int PW = 16;
  localparam logic [6:0] GRP_MAGIC = 7'h7F;
  localparam logic [3:0] BASE_PARCELS = 4'd5;

  typedef enum logic [2:0] {K_HDR, K_VLB, K_PRED, K_REG, K_OP} kind_e;

  typedef struct packed {
    logic       hv;    // length parcel present
    logic [1:0] np;    // predicate parcels
    logic [1:0] nr;    // register parcels
    logic       full;  // wide tag entries
    logic [3:0] last;  // index of final parcel
  } grp_cfg_t;
endpackage

// File: rtl/svg_hdr_decode.sv
`timescale 1ns/1ps
module svg_hdr_decode
  import svg_pkg::*;
(
  input  logic [PW-1:0] hdr_i,
  output grp_cfg_t      cfg_o,
  output logic          bad_o
);
  logic [2:0] il;
  logic [3:0] total, need;

  assign il    = hdr_i[14:12];
  assign total = BASE_PARCELS + {1'b0, il};
  assign need  = 4'd1 + {3'd0, hdr_i[15]} + {2'd0, hdr_i[11:10]} + {2'd0, hdr_i[9:8]};

  assign cfg_o.hv   = hdr_i[15];
  assign cfg_o.np   = hdr_i[11:10];
  assign cfg_o.nr   = hdr_i[9:8];
  assign cfg_o.full = hdr_i[7];
  assign cfg_o.last = total - 4'd1;

  assign bad_o = (hdr_i[6:0] != GRP_MAGIC) || (il == 3'b111) || (need > total);
endmodule

// File: rtl/svg_slot_map.sv
`timescale 1ns/1ps
module svg_slot_map
  import svg_pkg::*;
(
  input  logic       busy_i,
  input  logic [3:0] idx_i,
  input  grp_cfg_t   cfg_i,
  output kind_e      kind_o,
  output logic [1:0] sub_o
);
  logic [3:0] vend, pend, rend;

  assign vend = {3'd0, cfg_i.hv};
  assign pend = vend + {2'd0, cfg_i.np};
  assign rend = pend + {2'd0, cfg_i.nr};

  always_comb begin
    kind_o = K_HDR;
    sub_o  = 2'd0;
    if (!busy_i) begin
      kind_o = K_HDR;
    end else if (idx_i <= vend) begin
      kind_o = K_VLB;
    end else if (idx_i <= pend) begin
      kind_o = K_PRED;
      sub_o  = idx_i[1:0] - vend[1:0] - 2'd1;
    end else if (idx_i <= rend) begin
      kind_o = K_REG;
      sub_o  = idx_i[1:0] - pend[1:0] - 2'd1;
    end else begin
      kind_o = K_OP;
    end
  end
endmodule

// File: rtl/svg_tag_fmt.sv
`timescale 1ns/1ps
module svg_tag_fmt
  import svg_pkg::*;
(
  input  logic          fire_i,
  input  logic          pred_i,
  input  logic          full_i,
  input  logic [1:0]    sub_i,
  input  logic [PW-1:0] data_i,
  output logic [1:0]    valid_o,
  output logic          is_pred_o,
  output logic          full_o,
  output logic [PW-1:0] data_o,
  output logic [2:0]    idx_o,
  output logic [9:0]    preg_o
);
  logic [4:0] ent;
  assign ent = {2'd0, sub_i, 1'b0};

  always_comb begin
    valid_o   = 2'b00;
    is_pred_o = 1'b0;
    full_o    = 1'b0;
    data_o    = '0;
    idx_o     = 3'd0;
    preg_o    = '0;
    if (fire_i) begin
      is_pred_o = pred_i;
      full_o    = full_i;
      data_o    = data_i;
      if (full_i) begin
        valid_o = 2'b01;
        idx_o   = {1'b0, sub_i};
      end else begin
        valid_o = {|data_i[15:8], |data_i[7:0]};
        idx_o   = {sub_i, 1'b0};
        if (pred_i) preg_o = {5'd10 + ent, 5'd9 + ent};
      end
    end
  end
endmodule

// File: rtl/svg_vl_unit.sv
`timescale 1ns/1ps
module svg_vl_unit #(
  parameter int XLEN   = 64,
  parameter int VL_MAX = 64,
  localparam int VLW   = $clog2(VL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fire_i,
  input  logic            mode_i,
  input  logic [1:0]      sub_i,
  input  logic [4:0]      dest_i,
  input  logic [5:0]      len_i,
  output logic [4:0]      raddr_o,
  input  logic [XLEN-1:0] rdata_i,
  output logic            we_o,
  output logic [4:0]      waddr_o,
  output logic [XLEN-1:0] wdata_o,
  output logic [VLW-1:0]  vl_o,
  output logic [VLW-1:0]  maxvl_o,
  output logic [2:0]      subvl_o
);
  logic [VLW-1:0]  vl_q, maxvl_q;
  logic [2:0]      subvl_q;
  logic [6:0]      imm6p, imm5p;
  logic [XLEN-1:0] cand, lim, nv;

  assign imm6p = {1'b0, len_i} + 7'd1;
  assign imm5p = {2'd0, len_i[5:1]} + 7'd1;

  always_comb begin
    if (mode_i)        cand = XLEN'(imm6p);
    else if (len_i[0]) cand = (rdata_i == '0) ? XLEN'(1) : rdata_i;
    else               cand = XLEN'(imm5p);
    lim = mode_i ? XLEN'(VL_MAX) : XLEN'(maxvl_q);
    nv  = (cand > lim) ? lim : cand;
  end

  assign raddr_o = (fire_i && !mode_i && len_i[0]) ? len_i[5:1] : 5'd0;
  assign we_o    = fire_i && (dest_i != 5'd0);
  assign waddr_o = we_o ? dest_i : 5'd0;
  assign wdata_o = we_o ? nv : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q    <= VLW'(1);
      maxvl_q <= VLW'(1);
      subvl_q <= 3'd1;
    end else if (fire_i) begin
      subvl_q <= {1'b0, sub_i} + 3'd1;
      vl_q    <= nv[VLW-1:0];
      if (mode_i) maxvl_q <= nv[VLW-1:0];
    end
  end

  assign vl_o    = vl_q;
  assign maxvl_o = maxvl_q;
  assign subvl_o = subvl_q;

  p_vl_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_q != '0) && (vl_q <= maxvl_q));
  p_max_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !mode_i) |=> $stable(maxvl_q));
  p_subvl_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (subvl_q >= 3'd1) && (subvl_q <= 3'd4));
  p_wr_new_vl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> (vl_q == $past(wdata_o[VLW-1:0])));
endmodule

// File: rtl/svg_prefix_parser.sv
`timescale 1ns/1ps
module svg_prefix_parser
  import svg_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int VL_MAX = 64,
  localparam int VLW   = $clog2(VL_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [PW-1:0]   in_data_i,
  output logic            op_valid_o,
  input  logic            op_ready_i,
  output logic [PW-1:0]   op_data_o,
  output logic            grp_end_o,
  output logic            hdr_err_o,
  output logic [1:0]      tag_valid_o,
  output logic            tag_is_pred_o,
  output logic            tag_full_o,
  output logic [PW-1:0]   tag_data_o,
  output logic [2:0]      tag_idx_o,
  output logic [9:0]      tag_preg_o,
  output logic [4:0]      sreg_raddr_o,
  input  logic [XLEN-1:0] sreg_rdata_i,
  output logic            sreg_we_o,
  output logic [4:0]      sreg_waddr_o,
  output logic [XLEN-1:0] sreg_wdata_o,
  output logic [VLW-1:0]  vl_o,
  output logic [VLW-1:0]  maxvl_o,
  output logic [2:0]      subvl_o
);
  logic       busy_q;
  logic [3:0] idx_q;
  grp_cfg_t   cfg_q, cfg_d;
  logic       hdr_bad;
  kind_e      kind;
  logic [1:0] sub;
  logic       fire, is_last;

  svg_hdr_decode u_hdr (
    .hdr_i (in_data_i),
    .cfg_o (cfg_d),
    .bad_o (hdr_bad)
  );

  svg_slot_map u_map (
    .busy_i (busy_q),
    .idx_i  (idx_q),
    .cfg_i  (cfg_q),
    .kind_o (kind),
    .sub_o  (sub)
  );

  assign in_ready_o = (kind != K_OP) || op_ready_i;
  assign fire       = in_valid_i && in_ready_o;
  assign is_last    = busy_q && (idx_q == cfg_q.last);

  assign op_valid_o = in_valid_i && (kind == K_OP);
  assign op_data_o  = in_data_i;
  assign grp_end_o  = fire && is_last;
  assign hdr_err_o  = in_valid_i && (kind == K_HDR) && hdr_bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= 4'd0;
      cfg_q  <= '0;
    end else if (fire) begin
      if (kind == K_HDR) begin
        if (!hdr_bad) begin
          busy_q <= 1'b1;
          idx_q  <= 4'd1;
          cfg_q  <= cfg_d;
        end
      end else if (is_last) begin
        busy_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 4'd1;
      end
    end
  end

  svg_tag_fmt u_tag (
    .fire_i    (in_valid_i && ((kind == K_PRED) || (kind == K_REG))),
    .pred_i    (kind == K_PRED),
    .full_i    (cfg_q.full),
    .sub_i     (sub),
    .data_i    (in_data_i),
    .valid_o   (tag_valid_o),
    .is_pred_o (tag_is_pred_o),
    .full_o    (tag_full_o),
    .data_o    (tag_data_o),
    .idx_o     (tag_idx_o),
    .preg_o    (tag_preg_o)
  );

  svg_vl_unit #(.XLEN(XLEN), .VL_MAX(VL_MAX)) u_vl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (in_valid_i && (kind == K_VLB)),
    .mode_i  (in_data_i[15]),
    .sub_i   (in_data_i[14:13]),
    .dest_i  (in_data_i[12:8]),
    .len_i   (in_data_i[5:0]),
    .raddr_o (sreg_raddr_o),
    .rdata_i (sreg_rdata_i),
    .we_o    (sreg_we_o),
    .waddr_o (sreg_waddr_o),
    .wdata_o (sreg_wdata_o),
    .vl_o    (vl_o),
    .maxvl_o (maxvl_o),
    .subvl_o (subvl_o)
  );

  p_err_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |=> !busy_q);
  p_end_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grp_end_o |=> !busy_q);
  p_tag_in_group_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tag_valid_o != 2'b00) || op_valid_o) |-> busy_q);
  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !in_ready_o) |=> (busy_q && $stable(idx_q)));
endmodule

// File: tb/svg_prefix_parser_tb.sv
`timescale 1ns/1ps
module svg_prefix_parser_tb;
  localparam int XLEN   = 64;
  localparam int VL_MAX = 64;
  localparam int VLW    = $clog2(VL_MAX + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, op_ready_i = 1'b0;
  logic [15:0] in_data_i = '0;
  logic [XLEN-1:0] sreg_rdata_i = '0;
  logic in_ready_o, op_valid_o, grp_end_o, hdr_err_o, tag_is_pred_o, tag_full_o, sreg_we_o;
  logic [15:0] op_data_o, tag_data_o;
  logic [1:0] tag_valid_o;
  logic [2:0] tag_idx_o, subvl_o;
  logic [9:0] tag_preg_o;
  logic [4:0] sreg_raddr_o, sreg_waddr_o;
  logic [XLEN-1:0] sreg_wdata_o;
  logic [VLW-1:0] vl_o, maxvl_o;

  always #5 clk = ~clk;

  svg_prefix_parser #(.XLEN(XLEN), .VL_MAX(VL_MAX)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_data_i(in_data_i), .op_valid_o(op_valid_o), .op_ready_i(op_ready_i),
    .op_data_o(op_data_o), .grp_end_o(grp_end_o), .hdr_err_o(hdr_err_o),
    .tag_valid_o(tag_valid_o), .tag_is_pred_o(tag_is_pred_o), .tag_full_o(tag_full_o),
    .tag_data_o(tag_data_o), .tag_idx_o(tag_idx_o), .tag_preg_o(tag_preg_o),
    .sreg_raddr_o(sreg_raddr_o), .sreg_rdata_i(sreg_rdata_i), .sreg_we_o(sreg_we_o),
    .sreg_waddr_o(sreg_waddr_o), .sreg_wdata_o(sreg_wdata_o), .vl_o(vl_o),
    .maxvl_o(maxvl_o), .subvl_o(subvl_o)
  );

  int nvec = 0, nfail = 0, cyc = 0;
  bit done = 0;

  // reference state
  bit m_busy = 0, m_hv = 0, m_full = 0;
  int m_idx = 0, m_np = 0, m_nr = 0, m_last = 0;
  int m_vl = 1, m_max = 1, m_sub = 1;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hdr(input int hv, input int il, input int np, input int nr, input int full);
    return {hv[0], il[2:0], np[1:0], nr[1:0], full[0], 7'h7F};
  endfunction

  function automatic logic [15:0] vlp(input int mode, input int sub, input int dest, input int len);
    return {mode[0], sub[1:0], dest[4:0], 2'b00, len[5:0]};
  endfunction

  task automatic step(input logic v, input logic [15:0] d, input logic ordy,
                      input logic [63:0] rd, output logic acc);
    int kind, sub, il, need, x;
    bit bad, e_ready, tagf, vlf, e_we;
    logic [1:0] e_tv;
    logic [2:0] e_idx;
    logic [9:0] e_preg;
    logic [4:0] e_ra;
    logic [63:0] val;
    int n_vl, n_max, n_sub;
    in_valid_i = v; in_data_i = d; op_ready_i = ordy; sreg_rdata_i = rd;
    #1;
    sub = 0;
    if (!m_busy) kind = 0;
    else if (m_hv && m_idx == 1) kind = 1;
    else if (m_idx <= m_hv + m_np) begin kind = 2; sub = m_idx - m_hv - 1; end
    else if (m_idx <= m_hv + m_np + m_nr) begin kind = 3; sub = m_idx - m_hv - m_np - 1; end
    else kind = 4;
    il = d[14:12];
    need = 1 + d[15] + d[11:10] + d[9:8];
    bad = (d[6:0] != 7'h7F) || (il == 7) || (need > 5 + il);
    e_ready = (kind != 4) || ordy;
    acc = v && e_ready;
    chk("R11", "in_ready", in_ready_o, e_ready);
    chk("R3", "op_valid", op_valid_o, v && kind == 4);
    if (v && kind == 4) chk("R11", "op_data", op_data_o, d);
    chk("R1", "hdr_err", hdr_err_o, v && kind == 0 && bad);
    chk("R2", "grp_end", grp_end_o, acc && m_busy && m_idx == m_last);
    tagf = v && (kind == 2 || kind == 3);
    e_tv = 0; e_idx = 0; e_preg = 0;
    if (tagf) begin
      if (m_full) begin e_tv = 2'b01; e_idx = sub[2:0]; end
      else begin
        e_tv = {d[15:8] != 0, d[7:0] != 0};
        e_idx = 3'(2 * sub);
        if (kind == 2) e_preg = {5'(10 + 2 * sub), 5'(9 + 2 * sub)};
      end
    end
    chk("R4", "tag_valid", tag_valid_o, e_tv);
    chk("R3", "tag_is_pred", tag_is_pred_o, tagf && kind == 2);
    chk("R4", "tag_full", tag_full_o, tagf && m_full);
    chk("R3", "tag_data", tag_data_o, tagf ? d : 16'h0);
    chk("R5", "tag_idx", tag_idx_o, e_idx);
    chk("R5", "tag_preg", tag_preg_o, e_preg);
    vlf = v && kind == 1;
    n_vl = m_vl; n_max = m_max; n_sub = m_sub; e_ra = 0;
    if (vlf) begin
      n_sub = d[14:13] + 1;
      if (d[15]) begin
        x = d[5:0] + 1; if (x > VL_MAX) x = VL_MAX;
        n_max = x; n_vl = x;
      end else if (d[0]) begin
        e_ra = d[5:1];
        val = rd;
        if (val == 0) val = 1;
        if (val > 64'(m_max)) val = 64'(m_max);
        n_vl = int'(val);
      end else begin
        x = d[5:1] + 1;
        n_vl = (x < m_max) ? x : m_max;
      end
    end
    e_we = vlf && d[12:8] != 0;
    chk("R7", "sreg_raddr", sreg_raddr_o, e_ra);
    chk("R10", "sreg_we", sreg_we_o, e_we);
    chk("R10", "sreg_waddr", sreg_waddr_o, e_we ? d[12:8] : 5'd0);
    chk("R10", "sreg_wdata", sreg_wdata_o, e_we ? 64'(n_vl) : 64'd0);
    chk("R6", "vl", vl_o, m_vl);
    chk("R8", "maxvl", maxvl_o, m_max);
    chk("R9", "subvl", subvl_o, m_sub);
    @(posedge clk);
    cyc++;
    if (acc) begin
      if (kind == 0) begin
        if (!bad) begin
          m_busy = 1; m_idx = 1; m_hv = d[15]; m_np = d[11:10]; m_nr = d[9:8];
          m_full = d[7]; m_last = 4 + il;
        end
      end else if (m_idx == m_last) m_busy = 0;
      else m_idx++;
      if (vlf) begin m_vl = n_vl; m_max = n_max; m_sub = n_sub; end
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] d, input logic [63:0] rd = 64'd0);
    logic a;
    a = 0;
    while (!a) step(1'b1, d, (cyc % 4) != 1, rd, a);
  endtask

  task automatic idle(input int n);
    logic a;
    for (int i = 0; i < n; i++) step(1'b0, 16'hFFFF, 1'b0, 64'd0, a);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "reset in_ready", in_ready_o, 1'b1);
    chk("R12", "reset op_valid", op_valid_o, 1'b0);
    chk("R12", "reset vl", vl_o, 1);
    chk("R12", "reset maxvl", maxvl_o, 1);
    chk("R12", "reset subvl", subvl_o, 1);
    chk("R12", "reset sreg_we", sreg_we_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    idle(2);
    // mode 1 length parcel, 3 opcodes under back-pressure
    send(hdr(1, 0, 0, 0, 1)); send(vlp(1, 0, 5, 15));
    send(16'hA001); send(16'hA002); send(16'hA003);
    // wide tags, mode 0 immediate
    send(hdr(1, 2, 2, 1, 1)); send(vlp(0, 1, 3, 9 << 1));
    send(16'h1234); send(16'h5678); send(16'h9ABC); send(16'hB001); send(16'hB002);
    idle(1);
    // narrow tags with padding bytes, no length parcel
    send(hdr(0, 1, 2, 2, 0));
    send(16'h0A05); send(16'h0003); send(16'h1122); send(16'h0000); send(16'hC001);
    // register source, zero destination, value above MAXVL
    send(hdr(1, 0, 0, 0, 1)); send(vlp(0, 3, 0, (7 << 1) | 1), 64'd1000);
    send(16'hD001); send(16'hD002); send(16'hD003);
    // register source with zero value
    send(hdr(1, 0, 0, 0, 1)); send(vlp(0, 2, 2, (4 << 1) | 1), 64'd0);
    send(16'hD011); send(16'hD012); send(16'hD013);
    // mode 1 at the top of the range, then immediate below it
    send(hdr(1, 0, 0, 0, 1)); send(vlp(1, 1, 1, 63));
    send(16'hE001); send(16'hE002); send(16'hE003);
    send(hdr(1, 0, 0, 0, 1)); send(vlp(0, 0, 4, 31 << 1));
    send(16'hE011); send(16'hE012); send(16'hE013);
    // small MAXVL then immediate above it
    send(hdr(1, 0, 0, 0, 1)); send(vlp(1, 0, 6, 7));
    send(16'hE021); send(16'hE022); send(16'hE023);
    send(hdr(1, 0, 0, 0, 1)); send(vlp(0, 3, 7, 20 << 1));
    send(16'hE031); send(16'hE032); send(16'hE033);
    // malformed headers, then recovery
    send(hdr(0, 7, 0, 0, 1));
    send(16'h0000);
    send(hdr(1, 0, 3, 3, 1));
    // group with no opcode parcels
    send(hdr(1, 0, 2, 1, 1)); send(vlp(0, 0, 9, 2 << 1));
    send(16'h0101); send(16'h0202); send(16'h0303);
    // narrow predicate tags filling three parcels, longest group
    send(hdr(0, 6, 3, 1, 0));
    send(16'h0102); send(16'h0304); send(16'h0500); send(16'h0600);
    for (int i = 0; i < 7; i++) send(16'hF000 + 16'(i));
    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule